// File: doc/BRIEF.md
# I2C Byte Shifter with Completion-Flag Handshake

This block is the byte-level data path of a two-wire (I2C) serial controller. It holds one data byte. Software loads it before a transmission or reads it after a reception. The byte moves MSB-first against two single-cycle strobes from an external bit-timing unit. One strobe marks SCL going low, when the outgoing bit is placed. The other marks SCL rising, when the bus level is sampled. While a byte is going out, the level actually present on SDA is shifted back in. When the transfer ends, the register therefore holds whatever appeared on the bus, including bits that another device pulled low.

The ninth clock of every byte is the acknowledge slot, and the block handles it itself. As a receiver it drives ACK. As a transmitter it samples the ACK from the far end. When the acknowledge slot ends, a completion flag rises. While the flag is up, the data register accepts CPU writes and otherwise keeps its value. At every other time the register is locked against the CPU. Software releases the flag with a clear pulse, and that same pulse starts the next byte. The first byte after reset is started by a separate start strobe.

The block also holds a separate own-address register. It compares a received address byte against the stored 7-bit address, and recognises the general-call byte when that is enabled. START/STOP detection, bit-rate timing, arbitration and the protocol state machine sit outside the block. They reach it as plain strobes and level inputs.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `cpu_data_rdata` reads 0xFF, `cpu_addr_rdata` reads 0xFE, `irq_flag` is 0, `busy` is 0, `sda_out` is 1 (released), and `addr_hit` and `general_call_hit` are 0.
- R2: While a byte is transferring with `xmit`=1, each `scl_low_stb` among the first eight places the next bit of the data register on `sda_out`, most significant bit first. The bit is visible in the cycle after the strobe.
- R3: The first eight `scl_rise_stb` pulses of a transfer each shift the SDA level present in that cycle into the register's least significant bit. After the eighth pulse the register holds the byte seen on the bus, with the first-sampled bit in bit 7. This also holds while transmitting.
- R4: The ninth `scl_rise_stb` of a transfer sets `irq_flag` and clears `busy` in the next cycle. `flag_clr` while the flag is set clears it and starts a new transfer. `start_stb` starts a transfer only when the block is idle and the flag is clear. `irq_flag` and `busy` are never both 1.
- R5: `cpu_data_we` changes the data register only while `irq_flag` is 1. Writes made while the flag is 0, either idle before the first byte or during shifting, leave `cpu_data_rdata` unchanged.
- R6: While `irq_flag` is 1, SCL strobes and SDA activity leave the data register and `sda_out` unchanged.
- R7: A one-cycle `arb_lost` pulse during a transfer makes every later `scl_low_stb` of that byte release `sda_out` to 1. The bits already shifted in are kept, and the byte completes with the bus value.
- R8: In the acknowledge slot, the ninth `scl_low_stb` drives `sda_out` to 0 only when `xmit`=0, `ack_en`=1, and either `addr_phase`=0 or `addr_hit`=1. Otherwise it drives 1. With `xmit`=1, the ninth `scl_rise_stb` latches `ack_ok` = 1 if SDA was 0 and `ack_ok` = 0 if SDA was 1.
- R9: `cpu_addr_we` loads the own-address register at any time. Bits 7:1 hold the 7-bit address and bit 0 is the general-call enable. When `slave_mode`=1 and `addr_phase`=1, the eighth rise strobe sets `addr_hit` if received bits 7:1 equal the stored address. The hit outputs are held until the next transfer starts, which clears them.
- R10: A received byte of 0x00 in an address phase sets both `general_call_hit` and `addr_hit` only when the enable bit 0 is 1. When bit 0 is 0 it sets neither, unless the stored address is 0.
- R11: With `slave_mode`=0, no received byte sets `addr_hit` or `general_call_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_stb | input | 1 | Starts the first transfer when idle with flag clear |
| flag_clr | input | 1 | Clears the completion flag and starts the next transfer |
| scl_low_stb | input | 1 | SCL has gone low: place next bit |
| scl_rise_stb | input | 1 | SCL has risen: sample SDA |
| sda_in | input | 1 | Resolved SDA bus level |
| sda_out | output | 1 | SDA drive value (0 pulls low, 1 releases) |
| xmit | input | 1 | 1 = this byte is transmitted, 0 = received |
| slave_mode | input | 1 | Block operates as a slave |
| addr_phase | input | 1 | Current byte is an address byte |
| arb_lost | input | 1 | Arbitration-lost pulse, drop to slave |
| ack_en | input | 1 | Acknowledge received bytes |
| cpu_data_we | input | 1 | Data register write strobe |
| cpu_data_wdata | input | 8 | Data register write value |
| cpu_data_rdata | output | 8 | Data register contents |
| cpu_addr_we | input | 1 | Own-address register write strobe |
| cpu_addr_wdata | input | 8 | Own-address write value |
| cpu_addr_rdata | output | 8 | Own-address register contents |
| irq_flag | output | 1 | Byte-complete interrupt flag |
| busy | output | 1 | Transfer in progress |
| ack_ok | output | 1 | Last transmitted byte was acknowledged |
| addr_hit | output | 1 | Address byte matched own address or general call |
| general_call_hit | output | 1 | Address byte was an enabled general call |

## Verification
The checker assumes the bit-timing strobes are single-cycle pulses and that `scl_low_stb` and `scl_rise_stb` never fall in the same cycle. It assumes `flag_clr` and `start_stb` are pulsed only as one-cycle events, and that `arb_lost` comes only while a byte is moving. The bench drives every strobe at the falling clock edge for exactly one cycle. It alternates low and rise strobes with an idle cycle between them, and pulses `arb_lost` only between bits of a running transfer. This keeps the stimulus inside those assumptions.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  // 7-bit address compare against bits 7:1 of the own-address register
  function automatic logic addr_equal(input byte_t rx, input byte_t own);
    return rx[BYTE_W-1:1] == own[BYTE_W-1:1];
  endfunction

  // general-call byte is all zero, honoured only with enable bit 0 set
  function automatic logic gc_equal(input byte_t rx, input byte_t own);
    return (rx == '0) && own[0];
  endfunction
endpackage

// File: rtl/i2cbs_seq.sv
module i2cbs_seq
  import i2cbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_stb,
  input  logic             flag_clr,
  input  logic             scl_rise_stb,
  output logic             go,
  output logic             shift_evt,
  output logic             byte_done,
  output logic             ack_done,
  output logic             busy,
  output logic             irq_flag,
  output logic [CNT_W-1:0] bit_idx
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

  logic             busy_q, flag_q;
  logic [CNT_W-1:0] idx_q;

  assign go        = (start_stb && !busy_q && !flag_q) || (flag_clr && flag_q);
  assign shift_evt = busy_q && scl_rise_stb && (idx_q < ACK_SLOT);
  assign byte_done = shift_evt && (idx_q == LAST_DATA);
  assign ack_done  = busy_q && scl_rise_stb && (idx_q == ACK_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (shift_evt) begin
      idx_q  <= idx_q + 1'b1;
    end else if (ack_done) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (ack_done) flag_q <= 1'b1;
    else if (go)       flag_q <= 1'b0;
  end

  assign busy     = busy_q;
  assign irq_flag = flag_q;
  assign bit_idx  = idx_q;
endmodule

// File: rtl/i2cbs_shreg.sv
module i2cbs_shreg
  import i2cbs_pkg::*;
#(
  parameter byte_t RST_VAL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cpu_we,
  input  byte_t cpu_wdata,
  input  logic  flag,
  input  logic  shift_evt,
  input  logic  sda_in,
  output byte_t data,
  output byte_t rx_next
);
  byte_t data_q;

  assign rx_next = {data_q[BYTE_W-2:0], sda_in};

  always_ff @(posedge clk) begin
    if (!rst_n)                data_q <= RST_VAL;
    else if (cpu_we && flag)   data_q <= cpu_wdata;
    else if (shift_evt)        data_q <= rx_next;
  end

  assign data = data_q;
endmodule

// File: rtl/i2cbs_addr_cmp.sv
module i2cbs_addr_cmp
  import i2cbs_pkg::*;
#(
  parameter byte_t RST_VAL = 8'hFE
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  addr_we,
  input  byte_t addr_wdata,
  input  logic  go,
  input  logic  byte_done,
  input  byte_t rx_next,
  input  logic  slave_mode,
  input  logic  addr_phase,
  output byte_t own_addr,
  output logic  addr_hit,
  output logic  gc_hit
);
  byte_t own_q;
  logic  hit_q, gc_q;
  logic  cmp_en;

  assign cmp_en = byte_done && slave_mode && addr_phase;

  always_ff @(posedge clk) begin
    if (!rst_n)       own_q <= RST_VAL;
    else if (addr_we) own_q <= addr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || go) begin
      hit_q <= 1'b0;
      gc_q  <= 1'b0;
    end else if (cmp_en) begin
      hit_q <= addr_equal(rx_next, own_q) || gc_equal(rx_next, own_q);
      gc_q  <= gc_equal(rx_next, own_q);
    end
  end

  assign own_addr = own_q;
  assign addr_hit = hit_q;
  assign gc_hit   = gc_q;
endmodule

// File: rtl/i2cbs_sda_drv.sv
module i2cbs_sda_drv
  import i2cbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             busy,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             scl_low_stb,
  input  logic             ack_done,
  input  logic             xmit,
  input  logic             arb_lost,
  input  logic             data_msb,
  input  logic             ack_en,
  input  logic             addr_phase,
  input  logic             addr_hit,
  input  logic             sda_in,
  output logic             lost,
  output logic             sda_out,
  output logic             ack_ok
);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic lost_q, sda_q, ack_q;
  logic tx_act, ack_gen;

  assign tx_act  = xmit && !lost_q;
  assign ack_gen = !xmit && ack_en && (!addr_phase || addr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n || go)          lost_q <= 1'b0;
    else if (arb_lost && busy) lost_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || go || ack_done) begin
      sda_q <= 1'b1;
    end else if (busy && scl_low_stb) begin
      if (bit_idx < ACK_SLOT)       sda_q <= tx_act ? data_msb : 1'b1;
      else if (bit_idx == ACK_SLOT) sda_q <= !ack_gen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ack_q <= 1'b0;
    else if (ack_done && xmit) ack_q <= !sda_in;
  end

  assign lost    = lost_q;
  assign sda_out = sda_q;
  assign ack_ok  = ack_q;
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2cbs_pkg::*;
#(
  parameter byte_t DATA_RST = 8'hFF,
  parameter byte_t ADDR_RST = 8'hFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_stb,
  input  logic        flag_clr,
  input  logic        scl_low_stb,
  input  logic        scl_rise_stb,
  input  logic        sda_in,
  output logic        sda_out,
  input  logic        xmit,
  input  logic        slave_mode,
  input  logic        addr_phase,
  input  logic        arb_lost,
  input  logic        ack_en,
  input  logic        cpu_data_we,
  input  logic [7:0]  cpu_data_wdata,
  output logic [7:0]  cpu_data_rdata,
  input  logic        cpu_addr_we,
  input  logic [7:0]  cpu_addr_wdata,
  output logic [7:0]  cpu_addr_rdata,
  output logic        irq_flag,
  output logic        busy,
  output logic        ack_ok,
  output logic        addr_hit,
  output logic        general_call_hit
);
  // named internal events, visible to the bound checker
  logic             go, shift_evt, byte_done, ack_done, lost;
  logic [CNT_W-1:0] bit_idx;
  byte_t            data, rx_next;

  i2cbs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .flag_clr(flag_clr),
    .scl_rise_stb(scl_rise_stb), .go(go), .shift_evt(shift_evt),
    .byte_done(byte_done), .ack_done(ack_done), .busy(busy),
    .irq_flag(irq_flag), .bit_idx(bit_idx)
  );

  i2cbs_shreg #(.RST_VAL(DATA_RST)) u_shreg (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_data_we), .cpu_wdata(cpu_data_wdata),
    .flag(irq_flag), .shift_evt(shift_evt), .sda_in(sda_in),
    .data(data), .rx_next(rx_next)
  );

  i2cbs_addr_cmp #(.RST_VAL(ADDR_RST)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_we(cpu_addr_we), .addr_wdata(cpu_addr_wdata),
    .go(go), .byte_done(byte_done), .rx_next(rx_next),
    .slave_mode(slave_mode), .addr_phase(addr_phase),
    .own_addr(cpu_addr_rdata), .addr_hit(addr_hit), .gc_hit(general_call_hit)
  );

  i2cbs_sda_drv u_drv (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .bit_idx(bit_idx),
    .scl_low_stb(scl_low_stb), .ack_done(ack_done), .xmit(xmit),
    .arb_lost(arb_lost), .data_msb(data[BYTE_W-1]), .ack_en(ack_en),
    .addr_phase(addr_phase), .addr_hit(addr_hit), .sda_in(sda_in),
    .lost(lost), .sda_out(sda_out), .ack_ok(ack_ok)
  );

  assign cpu_data_rdata = data;
endmodule

// File: rtl/i2cbs_chk.sv
module i2cbs_chk
  import i2cbs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_flag,
  input logic             busy,
  input logic             shift_evt,
  input logic             ack_done,
  input logic             cpu_data_we,
  input logic [7:0]       cpu_data_rdata,
  input logic             addr_hit,
  input logic             general_call_hit,
  input logic             lost,
  input logic             scl_low_stb,
  input logic [CNT_W-1:0] bit_idx,
  input logic             sda_out
);
  // R6
  hold_while_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !cpu_data_we |=> $stable(cpu_data_rdata));

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag && !shift_evt |=> $stable(cpu_data_rdata));

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(ack_done));

  // R4
  flag_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_flag && busy));

  // R10
  gc_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    general_call_hit |-> addr_hit);

  // R7
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost && busy && scl_low_stb && (bit_idx < CNT_W'(BYTE_W)) |=> sda_out);
endmodule

bind i2c_byte_shifter i2cbs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .busy(busy),
  .shift_evt(shift_evt), .ack_done(ack_done), .cpu_data_we(cpu_data_we),
  .cpu_data_rdata(cpu_data_rdata), .addr_hit(addr_hit),
  .general_call_hit(general_call_hit), .lost(lost),
  .scl_low_stb(scl_low_stb), .bit_idx(bit_idx), .sda_out(sda_out)
);

// File: tb/i2c_byte_shifter_tb.sv
module i2c_byte_shifter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_stb = 0, flag_clr = 0, scl_low_stb = 0, scl_rise_stb = 0;
  logic xmit = 0, slave_mode = 0, addr_phase = 0, arb_lost = 0, ack_en = 1;
  logic cpu_data_we = 0, cpu_addr_we = 0;
  logic [7:0] cpu_data_wdata = 0, cpu_addr_wdata = 0;
  logic tb_sda = 1'b1;
  logic sda_out, sda_in, irq_flag, busy, ack_ok, addr_hit, general_call_hit;
  logic [7:0] cpu_data_rdata, cpu_addr_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tx_exp = 8'h00;
  logic flag_d = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_in = sda_out & tb_sda;   // wired-AND bus

  i2c_byte_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .flag_clr(flag_clr),
    .scl_low_stb(scl_low_stb), .scl_rise_stb(scl_rise_stb), .sda_in(sda_in),
    .sda_out(sda_out), .xmit(xmit), .slave_mode(slave_mode),
    .addr_phase(addr_phase), .arb_lost(arb_lost), .ack_en(ack_en),
    .cpu_data_we(cpu_data_we), .cpu_data_wdata(cpu_data_wdata),
    .cpu_data_rdata(cpu_data_rdata), .cpu_addr_we(cpu_addr_we),
    .cpu_addr_wdata(cpu_addr_wdata), .cpu_addr_rdata(cpu_addr_rdata),
    .irq_flag(irq_flag), .busy(busy), .ack_ok(ack_ok), .addr_hit(addr_hit),
    .general_call_hit(general_call_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: each rising completion flag pops one expected bus byte
  always @(negedge clk) begin
    if (rst_n && irq_flag && !flag_d) begin
      if (exp_q.size() == 0) check("R3 unexpected byte", 32'h1, 32'h0);
      else check("R3 byte on bus", {24'h0, cpu_data_rdata}, {24'h0, exp_q.pop_front()});
    end
    flag_d <= irq_flag;
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic cpu_wr(input logic [7:0] v);
    @(negedge clk) begin cpu_data_we = 1; cpu_data_wdata = v; end
    @(negedge clk) cpu_data_we = 0;
  endtask

  task automatic addr_wr(input logic [7:0] v);
    @(negedge clk) begin cpu_addr_we = 1; cpu_addr_wdata = v; end
    @(negedge clk) cpu_addr_we = 0;
  endtask

  task automatic begin_xfer();
    if (irq_flag) pulse(flag_clr);
    else          pulse(start_stb);
  endtask

  // driver: one byte plus ACK slot; drv = levels other devices put on SDA
  task automatic xfer(input logic [7:0] drv, input logic ack_lvl,
                      input int arb_at, input logic exp_ack_drive);
    logic [7:0] bus = '0;
    for (int i = 0; i < 8; i++) begin
      logic exp_bit;
      if (i == arb_at) pulse(arb_lost);
      pulse(scl_low_stb);
      exp_bit = (xmit && i < arb_at) ? tx_exp[7-i] : 1'b1;
      if (xmit && i < arb_at) check("R2 msb-first bit", {31'h0, sda_out}, {31'h0, exp_bit});
      else                    check("R7 released bit", {31'h0, sda_out}, 32'h1);
      tb_sda = drv[7-i];
      bus[7-i] = exp_bit & drv[7-i];
      pulse(scl_rise_stb);
      tb_sda = 1'b1;
    end
    pulse(scl_low_stb);
    check("R8 ack drive", {31'h0, sda_out}, {31'h0, exp_ack_drive});
    tb_sda = ack_lvl;
    exp_q.push_back(bus);
    pulse(scl_rise_stb);
    tb_sda = 1'b1;
    @(negedge clk);
    check("R4 flag after ack slot", {30'h0, irq_flag, busy}, 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 data reset", {24'h0, cpu_data_rdata}, 32'hFF);
    check("R1 addr reset", {24'h0, cpu_addr_rdata}, 32'hFE);
    check("R1 flag/busy/sda/hits", {27'h0, irq_flag, busy, sda_out, addr_hit, general_call_hit}, 32'h4);

    cpu_wr(8'h12);
    check("R5 write ignored before first byte", {24'h0, cpu_data_rdata}, 32'hFF);

    // receive 0xA5 as master receiver with ACK
    xmit = 0; ack_en = 1;
    begin_xfer();
    xfer(8'hA5, 1'b1, 8, 1'b0);
    cpu_wr(8'h3C);
    check("R5 write while flag set", {24'h0, cpu_data_rdata}, 32'h3C);

    // transmit 0x3C; mid-transfer write must be ignored; far end ACKs
    xmit = 1; tx_exp = 8'h3C;
    begin_xfer();
    check("R4 clear starts transfer", {30'h0, irq_flag, busy}, 32'h1);
    cpu_wr(8'h99);
    check("R5 write ignored while shifting", {24'h0, cpu_data_rdata}, 32'h3C);
    xfer(8'hFF, 1'b0, 8, 1'b1);
    check("R8 ack seen", {31'h0, ack_ok}, 32'h1);

    // transmit 0xF0 while another device pulls low: bus byte captured, NACK
    cpu_wr(8'hF0); tx_exp = 8'hF0;
    begin_xfer();
    xfer(8'h3C, 1'b1, 8, 1'b1);
    check("R8 nack seen", {31'h0, ack_ok}, 32'h0);

    // R6: strobes while flag is up change nothing
    tb_sda = 1'b0;
    pulse(scl_low_stb); pulse(scl_rise_stb); pulse(scl_low_stb); pulse(scl_rise_stb);
    tb_sda = 1'b1;
    check("R6 data held under flag", {24'h0, cpu_data_rdata}, 32'h30);
    check("R6 sda held under flag", {31'h0, sda_out}, 32'h1);
    pulse(start_stb);
    check("R4 start ignored while flag set", {30'h0, irq_flag, busy}, 32'h2);

    // R7: arbitration lost before bit 3
    cpu_wr(8'hC3); tx_exp = 8'hC3;
    begin_xfer();
    xfer(8'hEA, 1'b1, 3, 1'b1);
    check("R7 bits preserved", {24'h0, cpu_data_rdata}, 32'hCA);

    // address matching as slave receiver
    xmit = 0; slave_mode = 1; addr_phase = 1; ack_en = 1;
    addr_wr(8'hA9);
    check("R9 addr write", {24'h0, cpu_addr_rdata}, 32'hA9);
    begin_xfer();
    xfer(8'hA8, 1'b1, 8, 1'b0);
    check("R9 own address hit", {30'h0, addr_hit, general_call_hit}, 32'h2);
    begin_xfer();
    xfer(8'h00, 1'b1, 8, 1'b0);
    check("R10 general call enabled", {30'h0, addr_hit, general_call_hit}, 32'h3);
    addr_wr(8'hA8);
    begin_xfer();
    xfer(8'h00, 1'b1, 8, 1'b1);
    check("R10 general call disabled", {30'h0, addr_hit, general_call_hit}, 32'h0);
    begin_xfer();
    xfer(8'hA9, 1'b1, 8, 1'b0);
    check("R9 hit with read bit", {30'h0, addr_hit, general_call_hit}, 32'h2);
    slave_mode = 0;
    begin_xfer();
    xfer(8'hA8, 1'b1, 8, 1'b1);
    check("R11 no hit as master", {30'h0, addr_hit, general_call_hit}, 32'h0);
    slave_mode = 1; addr_phase = 0; ack_en = 0;
    begin_xfer();
    xfer(8'h5A, 1'b1, 8, 1'b1);
    check("R8 no ack when disabled", {30'h0, addr_hit, general_call_hit}, 32'h0);

    repeat (3) @(negedge clk);
    check("R3 all bytes seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule